// File: doc/BRIEF.md
# Fine-Grained Warp Issue Scheduler

This block decides, every clock cycle, which warp may place its next instruction into a shared SIMD pipeline. A warp is a group of threads that follow one program counter. The block keeps a small amount of state for each warp. Warps are interleaved cycle by cycle, so the latency of memory accesses and branches is hidden behind work from other warps. Each warp keeps its register state resident, so moving from one warp to another costs no cycles.

A warp may have only one instruction in flight. It stays out of selection until that instruction retires. No branch prediction is done, so a branching warp simply waits for its retire. A load that misses in the data cache parks only the warp that issued it. The other warps keep the pipeline busy until the fill for that warp arrives. Among the eligible warps, selection is round-robin. The search starts just after the warp that most recently won an accepted grant.

The grant is a combinational function of the per-warp state, the per-warp valid and ready inputs and the pipeline accept input. An issue takes effect at the clock edge on which the grant is high.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is in flight and none is parked. The round-robin pointer rests on the highest warp index, so the first accepted grant goes to the lowest-numbered eligible warp.
- R2: A warp is eligible only when its valid input and its ready input are both 1, it has no instruction in flight and it is not parked. Only an eligible warp can be granted.
- R3: Among eligible warps the grant goes to the first one found by searching upward from the index after the last accepted grant, wrapping from NUM_WARPS-1 to 0.
- R4: While `pipe_accept_i` is 0, `grant_valid_o` is 0 and the round-robin pointer does not move.
- R5: When no warp is eligible, `grant_valid_o` is 0 and `grant_wid_o` is 0. This is a bubble.
- R6: A granted warp counts as in flight from the next cycle. It becomes eligible again in the cycle after a retire notification (`retire_valid_i` with `retire_wid_i` equal to its index).
- R7: A miss notification for a warp clears its in-flight state and parks it from the next cycle. The warp stays parked until the cycle after a fill notification for it. Other warps remain selectable throughout.
- R8: If a fill and a miss name the same warp in the same cycle, the warp is parked in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_valid_i | input | NUM_WARPS | Warp is active and has instructions |
| warp_ready_i | input | NUM_WARPS | Warp's next instruction has its operands |
| pipe_accept_i | input | 1 | Pipeline can take an instruction this cycle |
| retire_valid_i | input | 1 | An instruction leaves the pipeline |
| retire_wid_i | input | WID_W | Warp of the retiring instruction |
| miss_valid_i | input | 1 | A data-cache miss is reported |
| miss_wid_i | input | WID_W | Warp that missed |
| fill_valid_i | input | 1 | Missing data has returned |
| fill_wid_i | input | WID_W | Warp whose data returned |
| grant_valid_o | output | 1 | An instruction issues this cycle |
| grant_wid_o | output | WID_W | Granted warp, 0 during a bubble |

## Verification
Two functions can collide in one cycle. A fill can clear a parked warp while a miss tries to park it again. A retire can free one warp while the arbiter grants another. The bench provokes the fill-with-miss case directly on one warp. It then leaves that warp as the only valid one and expects a bubble, and after a later fill it expects a grant to that warp. Retire and grant collisions arise constantly in the random phase. There a bench model, updated from the same inputs, predicts the next grant and judges every cycle.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    // per-warp scheduling state
    typedef struct packed {
        logic in_flight;
        logic parked;
    } slot_state_t;

endpackage

// File: rtl/wis_warp_slot.sv
module wis_warp_slot
    import warp_sched_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic ready_i,
    input  logic issue_i,
    input  logic retire_i,
    input  logic miss_i,
    input  logic fill_i,
    output logic eligible_o,
    output logic in_flight_o,
    output logic parked_o
);

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // retire or miss take the instruction out of the pipeline
        if (retire_i || miss_i) begin
            st_d.in_flight = 1'b0;
        end
        // an issue only happens to a warp with nothing in flight
        if (issue_i) begin
            st_d.in_flight = 1'b1;
        end
        // a miss wins over a fill for the same warp
        if (miss_i) begin
            st_d.parked = 1'b1;
        end else if (fill_i) begin
            st_d.parked = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eligible_o  = valid_i && ready_i && !st_q.in_flight && !st_q.parked;
    assign in_flight_o = st_q.in_flight;
    assign parked_o    = st_q.parked;

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int NUM_WARPS = 8,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0] eligible_i,
    input  logic [WID_W-1:0]     last_i,
    output logic                 found_o,
    output logic [WID_W-1:0]     pick_o
);

    always_comb begin
        found_o = 1'b0;
        pick_o  = '0;
        for (int off = 1; off <= NUM_WARPS; off++) begin
            int idx;
            idx = int'(last_i) + off;
            if (idx >= NUM_WARPS) begin
                idx = idx - NUM_WARPS;
            end
            if (!found_o && eligible_i[idx]) begin
                found_o = 1'b1;
                pick_o  = WID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
    parameter int NUM_WARPS = 8,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] warp_valid_i,
    input  logic [NUM_WARPS-1:0] warp_ready_i,
    input  logic                 pipe_accept_i,
    input  logic                 retire_valid_i,
    input  logic [WID_W-1:0]     retire_wid_i,
    input  logic                 miss_valid_i,
    input  logic [WID_W-1:0]     miss_wid_i,
    input  logic                 fill_valid_i,
    input  logic [WID_W-1:0]     fill_wid_i,
    output logic                 grant_valid_o,
    output logic [WID_W-1:0]     grant_wid_o
);

    typedef struct packed {
        logic [WID_W-1:0] last;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_WARPS-1:0] eligible;
    logic [NUM_WARPS-1:0] in_flight_q;
    logic [NUM_WARPS-1:0] parked_q;
    logic                 found;
    logic [WID_W-1:0]     pick;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
        wis_warp_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .valid_i     (warp_valid_i[w]),
            .ready_i     (warp_ready_i[w]),
            .issue_i     (grant_valid_o && (grant_wid_o == WID_W'(w))),
            .retire_i    (retire_valid_i && (retire_wid_i == WID_W'(w))),
            .miss_i      (miss_valid_i && (miss_wid_i == WID_W'(w))),
            .fill_i      (fill_valid_i && (fill_wid_i == WID_W'(w))),
            .eligible_o  (eligible[w]),
            .in_flight_o (in_flight_q[w]),
            .parked_o    (parked_q[w])
        );
    end

    wis_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
        .eligible_i (eligible),
        .last_i     (st_q.last),
        .found_o    (found),
        .pick_o     (pick)
    );

    always_comb begin
        st_d          = st_q;
        grant_valid_o = pipe_accept_i && found;
        grant_wid_o   = grant_valid_o ? pick : '0;
        if (grant_valid_o) begin
            st_d.last = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.last <= WID_W'(NUM_WARPS - 1);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
    parameter int NUM_WARPS = 8,
    localparam int WID_W    = $clog2(NUM_WARPS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_WARPS-1:0] warp_valid_i,
    input logic [NUM_WARPS-1:0] warp_ready_i,
    input logic                 pipe_accept_i,
    input logic                 miss_valid_i,
    input logic [WID_W-1:0]     miss_wid_i,
    input logic                 grant_valid_o,
    input logic [WID_W-1:0]     grant_wid_o,
    input logic [NUM_WARPS-1:0] in_flight_q,
    input logic [NUM_WARPS-1:0] parked_q,
    input logic [WID_W-1:0]     last_q
);

    p_no_grant_wo_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_accept_i |-> !grant_valid_o);

    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid_o |=> $stable(last_q));

    p_grant_inputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> (warp_valid_i[grant_wid_o] && warp_ready_i[grant_wid_o]));

    p_grant_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> (!in_flight_q[grant_wid_o] && !parked_q[grant_wid_o]));

    p_inflight_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !miss_valid_i) |=> in_flight_q[$past(grant_wid_o)]);

    p_miss_parks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid_i |=> parked_q[$past(miss_wid_i)]);

    p_bubble_wid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid_o |-> (grant_wid_o == '0));

endmodule

bind warp_issue_sched warp_issue_sched_chk #(.NUM_WARPS(NUM_WARPS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .warp_valid_i  (warp_valid_i),
    .warp_ready_i  (warp_ready_i),
    .pipe_accept_i (pipe_accept_i),
    .miss_valid_i  (miss_valid_i),
    .miss_wid_i    (miss_wid_i),
    .grant_valid_o (grant_valid_o),
    .grant_wid_o   (grant_wid_o),
    .in_flight_q   (in_flight_q),
    .parked_q      (parked_q),
    .last_q        (st_q.last)
);

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int WW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  vld = '0, rdy = '0;
    logic          acc = 1'b0;
    logic          ret_v = 1'b0, mis_v = 1'b0, fil_v = 1'b0;
    logic [WW-1:0] ret_w = '0, mis_w = '0, fil_w = '0;
    logic          gnt_v;
    logic [WW-1:0] gnt_w;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench model state
    bit m_inf [N];
    bit m_park[N];
    int m_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(N)) i_warp_issue_sched (
        .clk(clk), .rst_n(rst_n),
        .warp_valid_i(vld), .warp_ready_i(rdy), .pipe_accept_i(acc),
        .retire_valid_i(ret_v), .retire_wid_i(ret_w),
        .miss_valid_i(mis_v), .miss_wid_i(mis_w),
        .fill_valid_i(fil_v), .fill_wid_i(fil_w),
        .grant_valid_o(gnt_v), .grant_wid_o(gnt_w)
    );

    function automatic bit m_elig(int w);
        return vld[w] && rdy[w] && !m_inf[w] && !m_park[w];
    endfunction

    function automatic int m_pick();
        for (int off = 1; off <= N; off++) begin
            int idx = (m_last + off) % N;
            if (m_elig(idx)) return idx;
        end
        return -1;
    endfunction

    task automatic model_reset();
        for (int w = 0; w < N; w++) begin
            m_inf[w]  = 1'b0;
            m_park[w] = 1'b0;
        end
        m_last = N - 1;
    endtask

    task automatic clear_events();
        ret_v = 1'b0; mis_v = 1'b0; fil_v = 1'b0;
    endtask

    // check the grant for the present inputs, then advance one cycle
    task automatic step(input string tag);
        int  p;
        bit  ev;
        int  ew;
        #1;
        p  = acc ? m_pick() : -1;
        ev = (p >= 0);
        ew = ev ? p : 0;
        checks++;
        if (gnt_v !== ev || int'(gnt_w) != ew) begin
            errors++;
            $display("FAIL %s: grant valid/wid = %0b/%0d expected %0b/%0d at %0t",
                     tag, gnt_v, gnt_w, ev, ew, $time);
        end
        @(posedge clk);
        for (int w = 0; w < N; w++) begin
            if ((ret_v && int'(ret_w) == w) || (mis_v && int'(mis_w) == w)) m_inf[w] = 1'b0;
            if (ev && ew == w) m_inf[w] = 1'b1;
            if (mis_v && int'(mis_w) == w) m_park[w] = 1'b1;
            else if (fil_v && int'(fil_w) == w) m_park[w] = 1'b0;
        end
        if (ev) m_last = ew;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;

        // reset state: all warps able, pipeline closed
        vld = '1; rdy = '1; acc = 1'b0;
        step("R4 closed pipe");
        acc = 1'b1;
        step("R1 first grant to warp 0");
        step("R3 next warp in order");
        // retire warp 0 while warp 2 issues; miss on warp 1
        ret_v = 1'b1; ret_w = 0; mis_v = 1'b1; mis_w = 1;
        step("R6 retire with grant");
        clear_events();
        step("R6 rotation continues");
        rdy = '0;
        step("R2 none ready");
        rdy = '1;
        // fill and miss same warp in one cycle
        fil_v = 1'b1; fil_w = 1; mis_v = 1'b1; mis_w = 1;
        step("R8 fill with miss");
        clear_events();
        vld = 8'b0000_0010;
        step("R8 warp stays parked");
        step("R5 bubble");
        fil_v = 1'b1; fil_w = 1;
        step("R7 fill lands next cycle");
        clear_events();
        step("R7 parked warp granted after fill");
        vld = '1;
        // let every warp drain
        for (int w = 0; w < N; w++) begin
            ret_v = 1'b1; ret_w = WW'(w);
            step("R6 drain");
        end
        clear_events();

        // random phase
        for (int c = 0; c < 4000; c++) begin
            int fl_list[$];
            int pk_list[$];
            vld = WW'(0) | N'($urandom) | N'($urandom);
            rdy = N'($urandom) | N'($urandom);
            acc = ($urandom % 4) != 0;
            clear_events();
            for (int w = 0; w < N; w++) begin
                if (m_inf[w])  fl_list.push_back(w);
                if (m_park[w]) pk_list.push_back(w);
            end
            if (fl_list.size() > 0 && ($urandom % 2)) begin
                ret_v = 1'b1; ret_w = WW'(fl_list[$urandom % fl_list.size()]);
            end
            if (fl_list.size() > 0 && ($urandom % 5) == 0) begin
                int m = fl_list[$urandom % fl_list.size()];
                if (!(ret_v && int'(ret_w) == m)) begin
                    mis_v = 1'b1; mis_w = WW'(m);
                end
            end
            if (pk_list.size() > 0 && ($urandom % 3) == 0) begin
                fil_v = 1'b1; fil_w = WW'(pk_list[$urandom % pk_list.size()]);
            end
            if (!acc) step("R4 random closed");
            else if (mis_v || fil_v) step("R7 random miss/fill");
            else step("R3 random rotation");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule